// File: doc/BRIEF.md
# Page Program Collector

This block sits behind a byte-level SPI deserializer in a serial flash slave. It collects the page-program command: the opcode, a 24-bit address sent most significant byte first, and a stream of data bytes. The data bytes go into a one-page staging buffer, and the buffer keeps a valid flag for each byte. The low address bits give the starting offset in the page. The pointer wraps inside the page, so when more bytes are sent than the page holds, the newest bytes overwrite the older ones.

When chip select goes high after at least one whole data byte, the command is checked against the write-enable level and the protection window. If it passes, the block enters a timed busy phase. During that phase it walks the page and merges every flagged byte into a small on-chip array. The merge can only clear bits. When busy ends, the block pulses a request that clears the write-enable latch. A separate read port gives access to the array.

Top module: `pgm_page_buffer`

## Requirements
- R1: A command is recognised only when its first byte is 8'h02. It is followed by three address bytes, most significant first. Any other first byte leaves the array unchanged.
- R2: Address bits [7:0] give the first data offset. Bits [9:8] select the array page. Each data byte goes to the next offset, and offset 8'hFF is followed by offset 8'h00 of the same page.
- R3: When more than 256 data bytes are sent, each offset holds the last byte received for it. The page therefore reflects the final 256 bytes.
- R4: Bytes of the page that no data byte addressed, and all other pages, keep their previous contents.
- R5: Each committed byte equals the old array byte ANDed with the new data byte.
- R6: `busy` rises one clock after the edge at which `cs_n` is first sampled high on an accepted command. It stays high for exactly BUSY_CYCLES clocks.
- R7: A command is discarded if `wel_in` is 0 when `cs_n` rises. It is also discarded if `prot_on` is 1 and the target page index is greater than or equal to `prot_from`.
- R8: `wel_clr` is high for exactly one clock, in the first clock after `busy` falls. It is never high otherwise.
- R9: A command is discarded if `part_bits` is 1 when `cs_n` rises, or if no whole data byte was received.
- R10: A command whose opcode arrives while `busy` is 1 is discarded and does not restart the busy phase.
- R11: After reset, `busy` and `wel_clr` are 0 and every array byte reads 8'hFF. `rd_data` shows the byte at `rd_addr` one clock after the address is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select from the deserializer, active low |
| byte_vld | input | 1 | One whole received byte is present this clock |
| byte_in | input | 8 | Received byte |
| part_bits | input | 1 | The deserializer holds an incomplete byte |
| wel_in | input | 1 | Current write-enable latch value |
| prot_on | input | 1 | Protection window active |
| prot_from | input | ARR_PW | Lowest protected page index |
| rd_addr | input | ARR_PW+PAGE_AW | Array read address |
| rd_data | output | 8 | Array read data, one clock later |
| busy | output | 1 | Program phase in progress |
| wel_clr | output | 1 | One-clock request to clear the write-enable latch |

## Verification
The assertions assume a few things about the inputs. `byte_vld` is only meaningful while `cs_n` is low. `part_bits` is sampled together with the `cs_n` rise. `wel_in` and the protection inputs are stable at that same edge. The stimulus changes inputs only on falling clock edges. It raises `cs_n` on the clock after the last data byte, asserts `part_bits` only for that single clock, and changes `wel_in` and the protection inputs only between commands. The array is read back only while `busy` is low, because bytes are still being merged while it is high.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
   typedef enum logic [1:0] {
      RX_OP   = 2'd0,
      RX_ADR  = 2'd1,
      RX_DAT  = 2'd2,
      RX_SKIP = 2'd3
   } rx_state_t;

   localparam logic [7:0] OPC_PAGE_PROG = 8'h02;
endpackage

// File: rtl/pgm_cmd_rx.sv
module pgm_cmd_rx #(
   parameter int ADDR_W  = 24,
   parameter int PAGE_AW = 8,
   parameter int ARR_PW  = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cs_n,
   input  logic                byte_vld,
   input  logic [7:0]          byte_in,
   input  logic                part_bits,
   input  logic                wel_in,
   input  logic                prot_on,
   input  logic [ARR_PW-1:0]   prot_from,
   input  logic                busy,
   output logic                launch,
   output logic [ARR_PW-1:0]   launch_page,
   input  logic [PAGE_AW-1:0]  rd_off,
   output logic [7:0]          buf_byte,
   output logic                buf_vld
);
   import pgm_pkg::*;

   localparam int ADR_BYTES  = ADDR_W / 8;
   localparam int ACW        = (ADR_BYTES > 1) ? $clog2(ADR_BYTES) : 1;
   localparam int PAGE_BYTES = 1 << PAGE_AW;
   localparam int TW         = PAGE_AW + ARR_PW;

   rx_state_t            st;
   logic [ACW-1:0]       acnt;
   logic [TW-1:0]        addr_sr;
   logic [TW-1:0]        tgt_next;
   logic [PAGE_AW-1:0]   ptr;
   logic [ARR_PW-1:0]    page;
   logic                 got;
   logic [PAGE_BYTES-1:0] pvld;
   logic [7:0]           pbuf [PAGE_BYTES];
   logic                 take_data;

   assign tgt_next  = TW'({addr_sr, byte_in});
   assign take_data = !cs_n && byte_vld && (st == RX_DAT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= RX_OP;
         acnt    <= '0;
         addr_sr <= '0;
         ptr     <= '0;
         page    <= '0;
         got     <= 1'b0;
         pvld    <= '0;
      end else if (cs_n) begin
         st   <= RX_OP;
         acnt <= '0;
      end else if (byte_vld) begin
         unique case (st)
            RX_OP: begin
               if (byte_in == OPC_PAGE_PROG && !busy) begin
                  st   <= RX_ADR;
                  acnt <= '0;
                  got  <= 1'b0;
                  pvld <= '0;
               end else begin
                  st <= RX_SKIP;
               end
            end
            RX_ADR: begin
               addr_sr <= tgt_next;
               if (acnt == ACW'(ADR_BYTES - 1)) begin
                  st   <= RX_DAT;
                  ptr  <= tgt_next[PAGE_AW-1:0];
                  page <= tgt_next[PAGE_AW +: ARR_PW];
               end else begin
                  acnt <= acnt + 1'b1;
               end
            end
            RX_DAT: begin
               ptr       <= ptr + 1'b1;
               got       <= 1'b1;
               pvld[ptr] <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (take_data) pbuf[ptr] <= byte_in;
   end

   assign launch = cs_n && (st == RX_DAT) && got && !part_bits && wel_in
                   && !(prot_on && (page >= prot_from)) && !busy;
   assign launch_page = page;
   assign buf_byte    = pbuf[rd_off];
   assign buf_vld     = pvld[rd_off];
endmodule

// File: rtl/pgm_commit.sv
module pgm_commit #(
   parameter int PAGE_AW     = 8,
   parameter int ARR_PW      = 2,
   parameter int BUSY_CYCLES = 300
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      launch,
   input  logic [ARR_PW-1:0]         launch_page,
   input  logic [7:0]                buf_byte,
   input  logic                      buf_vld,
   output logic [PAGE_AW-1:0]        rd_off,
   output logic                      wr_en,
   output logic [ARR_PW+PAGE_AW-1:0] wr_addr,
   output logic [7:0]                wr_data,
   input  logic [7:0]                old_data,
   output logic                      busy,
   output logic                      wel_clr
);
   localparam int PAGE_BYTES = 1 << PAGE_AW;
   localparam int CW         = $clog2(BUSY_CYCLES + 1);

   logic [CW-1:0]     cnt;
   logic [ARR_PW-1:0] page;
   logic              in_window;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         wel_clr <= 1'b0;
         cnt     <= '0;
         page    <= '0;
      end else begin
         wel_clr <= 1'b0;
         if (!busy) begin
            cnt <= '0;
            if (launch) begin
               busy <= 1'b1;
               page <= launch_page;
            end
         end else if (cnt == CW'(BUSY_CYCLES - 1)) begin
            busy    <= 1'b0;
            wel_clr <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign in_window = busy && (cnt < CW'(PAGE_BYTES));
   assign rd_off    = cnt[PAGE_AW-1:0];
   assign wr_en     = in_window && buf_vld;
   assign wr_addr   = {page, rd_off};
   assign wr_data   = old_data & buf_byte;
endmodule

// File: rtl/pgm_array.sv
module pgm_array #(
   parameter int AW     = 10,
   parameter bit RD_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   output logic [7:0]    old_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign old_data = mem[wr_addr];

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (rst) rd_data <= 8'hFF;
            else     rd_data <= mem[rd_addr];
         end
      end else begin : g_rd_comb
         assign rd_data = mem[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/pgm_page_buffer.sv
module pgm_page_buffer #(
   parameter int ADDR_W      = 24,
   parameter int PAGE_AW     = 8,
   parameter int ARR_PW      = 2,
   parameter int BUSY_CYCLES = 300,
   parameter bit RD_REG      = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cs_n,
   input  logic                      byte_vld,
   input  logic [7:0]                byte_in,
   input  logic                      part_bits,
   input  logic                      wel_in,
   input  logic                      prot_on,
   input  logic [ARR_PW-1:0]         prot_from,
   input  logic [ARR_PW+PAGE_AW-1:0] rd_addr,
   output logic [7:0]                rd_data,
   output logic                      busy,
   output logic                      wel_clr
);
   localparam int ARR_AW     = ARR_PW + PAGE_AW;
   localparam int PAGE_BYTES = 1 << PAGE_AW;

   generate
      if (ADDR_W % 8 != 0) begin : g_bad_aw
         $error("ADDR_W must be a whole number of bytes");
      end
      if (ARR_AW > ADDR_W) begin : g_bad_arr
         $error("array address wider than command address");
      end
      if (BUSY_CYCLES <= PAGE_BYTES) begin : g_bad_busy
         $error("BUSY_CYCLES must exceed the page size");
      end
   endgenerate

   logic                launch;
   logic [ARR_PW-1:0]   launch_page;
   logic [PAGE_AW-1:0]  rd_off;
   logic [7:0]          buf_byte;
   logic                buf_vld;
   logic                wr_en;
   logic [ARR_AW-1:0]   wr_addr;
   logic [7:0]          wr_data;
   logic [7:0]          old_data;

   pgm_cmd_rx #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .ARR_PW(ARR_PW)) u_rx (
      .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld), .byte_in(byte_in),
      .part_bits(part_bits), .wel_in(wel_in), .prot_on(prot_on), .prot_from(prot_from),
      .busy(busy), .launch(launch), .launch_page(launch_page),
      .rd_off(rd_off), .buf_byte(buf_byte), .buf_vld(buf_vld)
   );

   pgm_commit #(.PAGE_AW(PAGE_AW), .ARR_PW(ARR_PW), .BUSY_CYCLES(BUSY_CYCLES)) u_commit (
      .clk(clk), .rst(rst), .launch(launch), .launch_page(launch_page),
      .buf_byte(buf_byte), .buf_vld(buf_vld), .rd_off(rd_off),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .old_data(old_data),
      .busy(busy), .wel_clr(wel_clr)
   );

   pgm_array #(.AW(ARR_AW), .RD_REG(RD_REG)) u_arr (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .old_data(old_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: rtl/pgm_page_buffer_chk.sv
module pgm_page_buffer_chk #(
   parameter int ARR_PW      = 2,
   parameter int BUSY_CYCLES = 300
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              part_bits,
   input logic              wel_in,
   input logic              prot_on,
   input logic [ARR_PW-1:0] prot_from,
   input logic [ARR_PW-1:0] launch_page,
   input logic              busy,
   input logic              wel_clr
);
   localparam int SW = $clog2(BUSY_CYCLES + 2);

   logic [SW-1:0] span;

   always_ff @(posedge clk) begin
      if (rst)       span <= '0;
      else if (busy) span <= span + 1'b1;
      else           span <= '0;
   end

   a_r6_busy_needs_cs: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(cs_n));

   a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (span == SW'(BUSY_CYCLES)));

   a_r7_busy_needs_wel: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(wel_in));

   a_r7_busy_not_prot: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !($past(prot_on) && ($past(launch_page) >= $past(prot_from))));

   a_r9_busy_whole_bytes: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !$past(part_bits));

   a_r8_clr_at_end: assert property (@(posedge clk) disable iff (rst)
      wel_clr |-> (!busy && $past(busy)));

   a_r8_clr_single: assert property (@(posedge clk) disable iff (rst)
      wel_clr |=> !wel_clr);
endmodule

bind pgm_page_buffer pgm_page_buffer_chk #(.ARR_PW(ARR_PW), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk(clk), .rst(rst), .cs_n(cs_n), .part_bits(part_bits), .wel_in(wel_in),
   .prot_on(prot_on), .prot_from(prot_from), .launch_page(launch_page),
   .busy(busy), .wel_clr(wel_clr)
);

// File: tb/tb_pgm_page_buffer.sv
module tb_pgm_page_buffer;
   localparam int PAGE_AW   = 8;
   localparam int ARR_PW    = 2;
   localparam int BUSY      = 300;
   localparam int ARR_AW    = PAGE_AW + ARR_PW;
   localparam int ARR_BYTES = 1 << ARR_AW;
   localparam int PB        = 1 << PAGE_AW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst, cs_n, byte_vld, part_bits, wel_in, prot_on;
   logic [7:0]        byte_in, rd_data;
   logic [ARR_PW-1:0] prot_from;
   logic [ARR_AW-1:0] rd_addr;
   logic              busy, wel_clr;

   pgm_page_buffer #(.PAGE_AW(PAGE_AW), .ARR_PW(ARR_PW), .BUSY_CYCLES(BUSY)) dut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld), .byte_in(byte_in),
      .part_bits(part_bits), .wel_in(wel_in), .prot_on(prot_on), .prot_from(prot_from),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .wel_clr(wel_clr)
   );

   int total = 0;
   int bad   = 0;

   logic [7:0]  mem_m [ARR_BYTES];
   int          m_left  = 0;
   bit          m_pulse = 1'b0;
   bit          m_armed = 1'b0;
   bit          m_ok    = 1'b0;
   bit          cmp_on  = 1'b0;
   logic [23:0] m_addr;
   logic [7:0]  m_q [$];

   function automatic void chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endfunction

   function automatic void apply_model();
      logic [7:0] nb [PB];
      bit         nv [PB];
      int         off;
      int         pg;
      for (int i = 0; i < PB; i++) begin nb[i] = 8'h00; nv[i] = 1'b0; end
      off = int'(m_addr[7:0]);
      pg  = int'(m_addr[9:8]);
      foreach (m_q[k]) begin
         nb[off] = m_q[k];
         nv[off] = 1'b1;
         off = (off + 1) % PB;
      end
      for (int i = 0; i < PB; i++)
         if (nv[i]) mem_m[pg*PB + i] = mem_m[pg*PB + i] & nb[i];
   endfunction

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      bit acc;
      m_pulse = 1'b0;
      if (rst) begin
         m_left = 0;
      end else begin
         acc = cs_n && m_armed && m_ok && (m_left == 0);
         if (cs_n && m_armed) m_armed = 1'b0;
         if (acc) begin
            apply_model();
            m_left = BUSY;
         end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) m_pulse = 1'b1;
         end
      end
   end

   // compared on every clock, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R6 busy", int'(busy), int'(m_left > 0));
         chk("R8 wel_clr", int'(wel_clr), int'(m_pulse));
      end
   end

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk);
      byte_vld = 1'b1;
      byte_in  = b;
   endtask

   task automatic pp(input logic [7:0] op, input logic [23:0] a, input int n,
                     input int seed, input bit part);
      logic [7:0] d;
      m_q.delete();
      @(negedge clk);
      cs_n = 1'b0;
      put_byte(op);
      put_byte(a[23:16]);
      put_byte(a[15:8]);
      put_byte(a[7:0]);
      for (int k = 0; k < n; k++) begin
         d = 8'(seed * 29 + k * 13 + (k >> 3) + 8'h5A);
         m_q.push_back(d);
         put_byte(d);
      end
      @(negedge clk);
      byte_vld  = 1'b0;
      cs_n      = 1'b1;
      part_bits = part;
      m_addr    = a;
      m_ok      = (op == 8'h02) && (n > 0) && !part && wel_in
                  && !(prot_on && (a[9:8] >= prot_from));
      m_armed   = 1'b1;
      @(negedge clk);
      part_bits = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_left > 0 || busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic verify(string tag);
      for (int i = 0; i < ARR_BYTES; i++) begin
         @(negedge clk);
         rd_addr = ARR_AW'(i);
         @(negedge clk);
         chk(tag, int'(rd_data), int'(mem_m[i]));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; cs_n = 1'b1; byte_vld = 1'b0; byte_in = 8'h00; part_bits = 1'b0;
      wel_in = 1'b1; prot_on = 1'b0; prot_from = '0; rd_addr = '0;
      for (int i = 0; i < ARR_BYTES; i++) mem_m[i] = 8'hFF;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      cmp_on = 1'b1;

      // R11: reset state
      chk("R11 busy", int'(busy), 0);
      chk("R11 wel_clr", int'(wel_clr), 0);
      verify("R11 erased array");

      // R1 / R4: short program in page 0
      pp(8'h02, 24'h000010, 4, 1, 1'b0);
      wait_idle();
      verify("R1 R4 short program");

      // R2: wrap across the page end in page 1
      pp(8'h02, 24'h0001FE, 5, 2, 1'b0);
      wait_idle();
      verify("R2 page wrap");

      // R3: 300 bytes into page 2, last 256 kept
      pp(8'h02, 24'h000220, 300, 3, 1'b0);
      wait_idle();
      verify("R3 last 256 kept");

      // R5: reprogram the same bytes, only bits clear
      pp(8'h02, 24'h000010, 8, 4, 1'b0);
      wait_idle();
      verify("R5 and merge");

      // R7: write enable low
      wel_in = 1'b0;
      pp(8'h02, 24'h000300, 4, 5, 1'b0);
      wait_idle();
      verify("R7 wel low ignored");
      wel_in = 1'b1;

      // R7: protected page 3 rejected, page 2 below the window accepted
      prot_on = 1'b1; prot_from = 2'd3;
      pp(8'h02, 24'h000340, 4, 6, 1'b0);
      wait_idle();
      pp(8'h02, 24'h000250, 4, 7, 1'b0);
      wait_idle();
      verify("R7 protection window");
      prot_on = 1'b0; prot_from = '0;

      // R9: partial byte at cs rise, and no data at all
      pp(8'h02, 24'h000100, 3, 8, 1'b1);
      wait_idle();
      pp(8'h02, 24'h000180, 0, 9, 1'b0);
      wait_idle();
      verify("R9 discarded");

      // R10: second command while busy
      pp(8'h02, 24'h000380, 4, 10, 1'b0);
      pp(8'h02, 24'h0003C0, 4, 11, 1'b0);
      wait_idle();
      verify("R10 busy rejects");

      // R1: foreign opcode
      pp(8'h03, 24'h0003A0, 4, 12, 1'b0);
      wait_idle();
      verify("R1 other opcode");

      cmp_on = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule